// File: doc/BRIEF.md
# Auto-Reload Interval Timer

A 32-bit down-counting interval timer on a single clock. Software reaches three registers over a simple write-strobe/address bus. While the enable bit is clear, it loads a starting count and a reload period. Setting the enable bit starts the countdown.

The count drops by one on every enabled cycle. When it sits at zero, the block raises a one-cycle interrupt request. In the same cycle it starts a four-cycle high pulse on the expiry pin. On the next cycle the count is refilled from the period register. Successive expiries are therefore period+1 cycles apart.

Register map (2-bit address): 0 = control (enable at bit 5), 1 = count, 2 = period, 3 = reserved. Reads are combinational from the address.

Top module: `interval_timer`

## Requirements
- R1: After reset, control, count and period read as zero, and `irq_o` and `expiry_o` are low.
- R2: The enable bit is bit 5 of the control register at address 0. A write there sets enable to wdata bit 5. Every other control bit reads as zero and has no effect.
- R3: While enabled and the count is non-zero, the count decreases by exactly one per cycle, modulo 2^32.
- R4: While disabled, the count holds its value unless it is written, and `irq_o` and `expiry_o` stay low.
- R5: `irq_o` is high in exactly those cycles in which the timer is enabled and the count is zero.
- R6: The cycle after an enabled zero, the count holds the period value. Interrupts then recur every period+1 cycles.
- R7: Each enabled zero drives `expiry_o` high for that cycle and the three following cycles, provided enable stays set.
- R8: With period zero and count zero, `irq_o` pulses every cycle and `expiry_o` stays continuously high.
- R9: A write to the count register (address 1) sets the count to wdata on the next cycle. It overrides both the decrement and the reload.
- R10: A write to the period register (address 2) leaves the running count untouched and is used at the next reload.
- R11: Clearing enable during an expiry pulse drops `expiry_o` in the first cycle after the write.
- R12: Reads return control at address 0, count at address 1, period at address 2, and zero at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address for read and write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| irq_o | output | 1 | One-cycle interrupt request at each enabled zero |
| expiry_o | output | 1 | Stretched expiry pulse |

## Verification
The assertions take for granted that write strobe, address and data are stable across each clock edge and never unknown once reset is released. They place no limit on when writes may arrive. The stimulus changes bus inputs only shortly after a rising edge.

The stimulus deliberately places writes in awkward cycles: the zero cycle, the middle of a pulse, and during a countdown. This exercises the priority and cancellation rules. It also uses an all-ones count to exercise wrap-free decrement near the top of the range.

// File: rtl/itimer_pkg.sv
package itimer_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_COUNT  = 2'd1,
    ADDR_PERIOD = 2'd2,
    ADDR_RSVD   = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic ctrl;
    logic count;
    logic period;
  } wr_strobe_t;
endpackage

// File: rtl/itimer_regs.sv
module itimer_regs
  import itimer_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int EN_BIT = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [WIDTH-1:0] count_i,
  output logic             enable_o,
  output logic [WIDTH-1:0] period_o,
  output wr_strobe_t       wr_o,
  output logic [WIDTH-1:0] rdata_o
);
  reg_addr_e  addr;
  logic       enable_q;
  logic [WIDTH-1:0] period_q;
  logic [WIDTH-1:0] ctrl_view;

  assign addr = reg_addr_e'(addr_i);

  always_comb begin
    wr_o        = '0;
    wr_o.ctrl   = we_i && (addr == ADDR_CTRL);
    wr_o.count  = we_i && (addr == ADDR_COUNT);
    wr_o.period = we_i && (addr == ADDR_PERIOD);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q <= 1'b0;
      period_q <= '0;
    end else begin
      if (wr_o.ctrl)   enable_q <= wdata_i[EN_BIT];
      if (wr_o.period) period_q <= wdata_i;
    end
  end

  always_comb begin
    ctrl_view         = '0;
    ctrl_view[EN_BIT] = enable_q;
  end

  always_comb begin
    unique case (addr)
      ADDR_CTRL:   rdata_o = ctrl_view;
      ADDR_COUNT:  rdata_o = count_i;
      ADDR_PERIOD: rdata_o = period_q;
      default:     rdata_o = '0;
    endcase
  end

  assign enable_o = enable_q;
  assign period_o = period_q;

  AST_CTRL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == 2'd0 |=> enable_o == $past(wdata_i[EN_BIT])); // R2
  AST_PERIOD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == 2'd2) |=> $stable(period_o)); // R10
endmodule

// File: rtl/itimer_counter.sv
module itimer_counter #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic [WIDTH-1:0] period_i,
  output logic [WIDTH-1:0] count_o,
  output logic             expire_o
);
  logic [WIDTH-1:0] count_q;
  logic             at_zero;

  assign at_zero  = (count_q == '0);
  assign expire_o = enable_i && at_zero;

  // bus load beats both reload and decrement
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          count_q <= '0;
    else if (load_i)      count_q <= load_val_i;
    else if (enable_i) begin
      if (at_zero)        count_q <= period_i;
      else                count_q <= count_q - WIDTH'(1);
    end
  end

  assign count_o = count_q;

  AST_DECREMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && !load_i && count_o != '0 |=> count_o == $past(count_o) - WIDTH'(1)); // R3
  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i && !load_i |=> $stable(count_o)); // R4
  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o && !load_i |=> count_o == $past(period_i)); // R6
  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> count_o == $past(load_val_i)); // R9
endmodule

// File: rtl/itimer_stretch.sv
module itimer_stretch #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int CW = (PULSE_LEN > 2) ? $clog2(PULSE_LEN) : 1;

  generate
    if (PULSE_LEN <= 1) begin : g_pass
      assign pulse_o = enable_i && trig_i;
    end else begin : g_cnt
      localparam logic [CW-1:0] HOLD = CW'(PULSE_LEN - 1);
      logic [CW-1:0] left_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              left_q <= '0;
        else if (!enable_i)       left_q <= '0;
        else if (trig_i)          left_q <= HOLD;   // retrigger restarts
        else if (left_q != '0)    left_q <= left_q - CW'(1);
      end

      assign pulse_o = enable_i && (trig_i || left_q != '0);

      AST_PULSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_i && enable_i |=> !enable_i || pulse_o); // R7
    end
  endgenerate

  AST_NO_SPONTANEOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o && !trig_i |-> $past(pulse_o)); // R7
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itimer_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int EN_BIT    = 5,
  parameter int PULSE_LEN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [WIDTH-1:0] reg_wdata_i,
  output logic [WIDTH-1:0] reg_rdata_o,
  output logic             irq_o,
  output logic             expiry_o
);
  logic             enable;
  logic [WIDTH-1:0] period;
  logic [WIDTH-1:0] count;
  wr_strobe_t       wr;
  logic             expire;

  itimer_regs #(.WIDTH(WIDTH), .EN_BIT(EN_BIT)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .count_i  (count),
    .enable_o (enable),
    .period_o (period),
    .wr_o     (wr),
    .rdata_o  (reg_rdata_o)
  );

  itimer_counter #(.WIDTH(WIDTH)) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (enable),
    .load_i     (wr.count),
    .load_val_i (reg_wdata_i),
    .period_i   (period),
    .count_o    (count),
    .expire_o   (expire)
  );

  itimer_stretch #(.PULSE_LEN(PULSE_LEN)) u_stretch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable),
    .trig_i   (expire),
    .pulse_o  (expiry_o)
  );

  assign irq_o = expire;

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable |-> !irq_o && !expiry_o); // R4
  AST_IRQ_IN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> expiry_o); // R7
  AST_IRQ_ONLY_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> count == '0); // R5
  AST_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == 2'd0 && !reg_wdata_i[EN_BIT] |=> !expiry_o); // R11
endmodule

// File: tb/interval_timer_tb.sv
`timescale 1ns/1ps
module interval_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd1;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  wire         irq;
  wire         expiry;

  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  string phase = "R1";

  // reference model state
  logic        m_en;
  logic [31:0] m_count;
  logic [31:0] m_period;
  int          m_str;

  interval_timer u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq),
    .expiry_o    (expiry)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [1:0] a);
    case (a)
      2'd0:    return m_en ? 32'h20 : 32'h0;
      2'd1:    return m_count;
      2'd2:    return m_period;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 1'b0; m_count = '0; m_period = '0; m_str = 0;
    end else begin
      logic        n_en;
      logic [31:0] n_count, n_period;
      int          n_str;
      cyc++;
      n_en = m_en; n_count = m_count; n_period = m_period; n_str = m_str;
      if (!m_en)              n_str = 0;
      else if (m_count == 0)  n_str = 3;
      else if (m_str > 0)     n_str = m_str - 1;
      if (m_en) n_count = (m_count == 0) ? m_period : m_count - 1;
      if (we && addr == 2'd1) n_count = wdata;
      if (we && addr == 2'd2) n_period = wdata;
      if (we && addr == 2'd0) n_en = wdata[5];
      m_en = n_en; m_count = n_count; m_period = n_period; m_str = n_str;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk({phase, " irq"},    {31'b0, irq},    {31'b0, m_en && m_count == 0});
      chk({phase, " expiry"}, {31'b0, expiry}, {31'b0, m_en && (m_count == 0 || m_str > 0)});
      chk({phase, " rdata"},  rdata,           m_read(addr));
    end
  end

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0; addr = 2'd1; wdata = '0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int t0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    for (int a = 0; a < 3; a++) begin
      addr = 2'(a); #1;
      chk("R1 reset rdata", rdata, 32'h0);
    end
    chk("R1 reset irq", {31'b0, irq}, 32'h0);
    chk("R1 reset expiry", {31'b0, expiry}, 32'h0);
    addr = 2'd1;
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    // R12 / R2: register access and control bit position
    phase = "R12";
    wr(2'd2, 32'd5);
    wr(2'd1, 32'd3);
    addr = 2'd3; #1; chk("R12 reserved reads zero", rdata, 32'h0);
    addr = 2'd2; #1; chk("R12 period readback", rdata, 32'd5);
    addr = 2'd1;
    phase = "R2";
    wr(2'd0, 32'hFFFF_FFDF);
    addr = 2'd0; #1; chk("R2 non-enable bits ignored", rdata, 32'h0);
    addr = 2'd1;
    phase = "R4";
    idle(4);
    chk("R4 count held while disabled", rdata, 32'd3);

    // R3 R5 R6 R7: free-running countdown
    phase = "R3";
    wr(2'd0, 32'h20);
    addr = 2'd0; #1; chk("R2 enable reads at bit 5", rdata, 32'h20);
    addr = 2'd1;
    phase = "R6";
    while (irq !== 1'b1) idle(1);
    t0 = cyc;
    idle(1);
    chk("R6 reload to period", rdata, 32'd5);
    while (irq !== 1'b1) idle(1);
    chk("R6 interval period+1", 32'(cyc - t0), 32'd6);
    phase = "R7";
    idle(3);
    chk("R7 expiry still high 3 cycles on", {31'b0, expiry}, 32'h1);
    idle(1);
    chk("R7 expiry low after 4 cycles", {31'b0, expiry}, 32'h0);

    // R10: period write mid-count
    phase = "R10";
    wr(2'd2, 32'd2);
    idle(12);

    // R9: count write beats reload in the zero cycle
    phase = "R9";
    while (irq !== 1'b1) idle(1);
    wr(2'd1, 32'd9);
    chk("R9 write wins over reload", rdata, 32'd9);
    idle(3);
    wr(2'd1, 32'hFFFF_FFFF);
    phase = "R3";
    idle(3);
    chk("R3 large count decrements", rdata, 32'hFFFF_FFFC);
    wr(2'd1, 32'd1);
    idle(4);

    // R11: disable cancels the pulse
    phase = "R11";
    while (irq !== 1'b1) idle(1);
    idle(1);
    wr(2'd0, 32'h0);
    chk("R11 expiry cut", {31'b0, expiry}, 32'h0);
    phase = "R4";
    idle(5);

    // R8: period zero
    phase = "R8";
    wr(2'd2, 32'd0);
    wr(2'd1, 32'd0);
    wr(2'd0, 32'h20);
    for (int i = 0; i < 8; i++) begin
      chk("R8 expiry continuous", {31'b0, expiry}, 32'h1);
      chk("R8 irq every cycle", {31'b0, irq}, 32'h1);
      idle(1);
    end
    wr(2'd0, 32'h0);
    phase = "R4";
    idle(3);

    summary();
    $finish;
  end
endmodule